// File: doc/BRIEF.md
# Smartcard receive parity checker with NACK

This block receives asynchronous half-duplex smartcard characters on one open-drain data line that is sampled at sixteen times the bit rate. A character is a low start bit, eight data bits sent least significant first, one even parity bit and a stop period of one and a half bit times. The receiver decides each bit by a majority vote of three samples around the middle of the bit. It presents the byte with status flags, and when the parity check fails it answers on the line itself. It pulls the line low in the second part of the stop period so the sender knows to repeat the character.

The oversampling tick comes from an external baud generator. The NACK answer can be switched off in block mode (the protocol in which errors are handled at block level) through a NACK-enable input. In character mode the answer is always given. The top-level line drive output is active high and means "pull the line low". Outside the block it is wired-AND with the card's own open-drain driver.

Top module: `sc_rx_parity`

## Requirements
- R1: After reset the block is idle: `rx_valid`, `line_pull_low`, `parity_err`, `noise_err` and `frame_err` are 0 and `rx_data` is 0.
- R2: Every bit level is the majority of the line samples taken on the 8th, 9th and 10th oversampling ticks of that bit, so one wrong sample among the three does not change the received value.
- R3: If any bit of a character has a vote that is not unanimous (one or two of the three samples high), `noise_err` is 1 when that character is presented, and otherwise it is 0.
- R4: A low level that has not stayed low by majority at the middle of the start bit is treated as a glitch. No character is presented and the block waits for the next falling edge.
- R5: The eight data bits are taken least significant bit first. They appear on `rx_data` together with a `rx_valid` pulse one clock long, issued on the 10th tick of the stop period.
- R6: Parity is even: `parity_err` is 1 when the XOR of the eight data bits and the parity bit is 1. The byte is presented in either case.
- R7: `frame_err` is 1 when the majority vote on the 8th to 10th ticks of the stop period is low.
- R8: On a parity error with NACK allowed, `line_pull_low` is asserted from the 11th through the 24th tick of the stop period (14 ticks) and is released when the 1.5-bit stop period ends. Otherwise it stays 0.
- R9: NACK is allowed when `block_mode` is 0 (whatever `nack_en` is) or when `block_mode` and `nack_en` are both 1. With `block_mode`=1 and `nack_en`=0 a parity error does not drive the line.
- R10: After the 24th stop tick the block is idle again and accepts a start bit on the very next tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| os_tick | input | 1 | Oversampling enable, 16 per bit time |
| rx_in | input | 1 | Data line level as seen on the wire |
| nack_en | input | 1 | Allows the NACK answer in block mode |
| block_mode | input | 1 | 1 selects block mode, 0 character mode |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-clock strobe for a new character |
| parity_err | output | 1 | Parity failed on the last character |
| noise_err | output | 1 | A split vote occurred on the last character |
| frame_err | output | 1 | Stop period sampled low |
| line_pull_low | output | 1 | Open-drain drive, 1 pulls the line low |

## Verification
Random bytes are sent with and without a flipped parity bit, under all four combinations of `nack_en` and `block_mode`. This separates a correct parity decision from a correct choice about whether to drive the line. A single inverted sample is injected in a random bit at tick 8, 9 or 10. Such a sample must raise the noise flag but leave the data and parity results unchanged, which tells a majority vote apart from single-point sampling. Directed cases cover a short low glitch that must be rejected, a stop period held low, the exact length of the NACK drive, and a frame that starts on the first tick after the stop period ends.

// File: rtl/sc_rx_parity.sv
module sc_rx_parity #(
  parameter int OSR   = 16,
  parameter int DBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             os_tick,
  input  logic             rx_in,
  input  logic             nack_en,
  input  logic             block_mode,
  output logic [DBITS-1:0] rx_data,
  output logic             rx_valid,
  output logic             parity_err,
  output logic             noise_err,
  output logic             frame_err,
  output logic             line_pull_low
);
  localparam int STOP_LEN = OSR + OSR / 2;
  localparam int CW       = $clog2(STOP_LEN + 1);
  localparam int BW       = $clog2(DBITS + 3);
  localparam logic [CW-1:0] S_FIRST = CW'(OSR / 2);
  localparam logic [CW-1:0] S_LAST  = CW'(OSR / 2 + 2);
  localparam logic [CW-1:0] T_BIT   = CW'(OSR);
  localparam logic [CW-1:0] T_STOP  = CW'(STOP_LEN);
  localparam logic [BW-1:0] PAR_IDX = BW'(DBITS + 1);

  typedef enum logic [1:0] {IDLE, RXB, STOP} st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic [BW-1:0]    bitn;
  logic [1:0]       ones;
  logic [DBITS-1:0] shreg;
  logic             par_b;
  logic             noise_acc;

  logic [CW-1:0] t;
  logic          smp, last, vote, split, perr, nack_ok;
  logic [1:0]    ones_nx;

  assign t       = cnt + 1'b1;
  assign smp     = (t >= S_FIRST) && (t <= S_LAST);
  assign last    = (t == S_LAST);
  assign ones_nx = ones + {1'b0, rx_in};
  assign vote    = ones_nx >= 2'd2;
  assign split   = (ones_nx == 2'd1) || (ones_nx == 2'd2);
  assign perr    = ^{shreg, par_b};
  assign nack_ok = !block_mode || nack_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= IDLE;
      cnt           <= '0;
      bitn          <= '0;
      ones          <= '0;
      shreg         <= '0;
      par_b         <= 1'b0;
      noise_acc     <= 1'b0;
      rx_data       <= '0;
      rx_valid      <= 1'b0;
      parity_err    <= 1'b0;
      noise_err     <= 1'b0;
      frame_err     <= 1'b0;
      line_pull_low <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (os_tick) begin
        case (st)
          IDLE: begin
            if (!rx_in) begin
              st        <= RXB;
              cnt       <= CW'(1);
              bitn      <= '0;
              ones      <= '0;
              noise_acc <= 1'b0;
            end
          end
          RXB: begin
            cnt <= t;
            if (smp) ones <= ones_nx;
            if (last) begin
              ones      <= '0;
              noise_acc <= noise_acc | split;
              if (bitn == '0) begin
                if (vote) st <= IDLE;
              end else if (bitn <= BW'(DBITS)) begin
                shreg <= {vote, shreg[DBITS-1:1]};
              end else begin
                par_b <= vote;
              end
            end
            if (t == T_BIT) begin
              cnt  <= '0;
              bitn <= bitn + 1'b1;
              if (bitn == PAR_IDX) st <= STOP;
            end
          end
          STOP: begin
            cnt <= t;
            if (smp) ones <= ones_nx;
            if (last) begin
              ones          <= '0;
              rx_valid      <= 1'b1;
              rx_data       <= shreg;
              parity_err    <= perr;
              noise_err     <= noise_acc | split;
              frame_err     <= !vote;
              line_pull_low <= perr && nack_ok;
            end
            if (t == T_STOP) begin
              st            <= IDLE;
              cnt           <= '0;
              line_pull_low <= 1'b0;
            end
          end
          default: st <= IDLE;
        endcase
      end
    end
  end

  p_drive_in_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    line_pull_low |-> (st == STOP));

  p_idle_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE) |-> !line_pull_low);

  p_valid_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_valid_in_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (st == STOP));

  p_nack_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_pull_low) |-> (parity_err && (!block_mode || nack_en)));

  p_nack_with_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_pull_low) |-> rx_valid);

endmodule

// File: tb/sc_rx_parity_tb.sv
module sc_rx_parity_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       os_tick = 1'b0;
  logic       rx_drv = 1'b1;
  logic       nack_en = 1'b0;
  logic       block_mode = 1'b0;
  logic [7:0] rx_data;
  logic       rx_valid, parity_err, noise_err, frame_err, line_pull_low;
  logic       line;

  int nchk = 0;
  int nfail = 0;

  int         got = 0;
  logic [7:0] c_data = '0;
  logic       c_perr = 0, c_noise = 0, c_frame = 0;
  int         drv_cnt = 0;

  assign line = rx_drv & ~line_pull_low;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_rx_parity u_dut (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_in(line),
    .nack_en(nack_en), .block_mode(block_mode),
    .rx_data(rx_data), .rx_valid(rx_valid), .parity_err(parity_err),
    .noise_err(noise_err), .frame_err(frame_err), .line_pull_low(line_pull_low)
  );

  always @(negedge clk) begin
    if (rx_valid) begin
      got++;
      c_data  = rx_data;
      c_perr  = parity_err;
      c_noise = noise_err;
      c_frame = frame_err;
    end
    if (line_pull_low) drv_cnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic lvl);
    rx_drv  = lvl;
    os_tick = 1'b1;
    @(negedge clk);
    os_tick = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic bit_level(input logic [7:0] d, input int b, input bit flip, input bit stop_low);
    if (b == 0) return 1'b0;
    if (b <= 8) return d[b-1];
    if (b == 9) return (^d) ^ flip;
    return !stop_low;
  endfunction

  function automatic int nack_expected(input bit flip, input logic blk, input logic ne);
    return (flip && (!blk || ne)) ? 14 * 2 : 0;
  endfunction

  task automatic send_frame(input logic [7:0] d, input bit flip, input int nbit,
                            input int ntick, input bit stop_low, input int gap);
    got = 0;
    drv_cnt = 0;
    for (int b = 0; b < 11; b++)
      for (int t = 1; t <= 16; t++) begin
        logic lvl;
        lvl = bit_level(d, b, flip, stop_low);
        if (b == nbit && t == ntick) lvl = !lvl;
        tick(lvl);
      end
    for (int t = 0; t < 8; t++) tick(1'b1);
    for (int t = 0; t < gap; t++) tick(1'b1);
  endtask

  task automatic check_frame(input logic [7:0] d, input bit flip, input bit noisy, input bit stop_low);
    chk("R5 one valid per frame", got, 1);
    chk("R5 R2 data", c_data, d);
    chk("R6 parity flag", c_perr, flip);
    chk("R3 noise flag", c_noise, noisy);
    chk("R7 framing flag", c_frame, stop_low);
    chk("R8 R9 nack length", drv_cnt, nack_expected(flip, block_mode, nack_en));
    chk("R8 released", line_pull_low, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 300000);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk("R1 valid", rx_valid, 0);
    chk("R1 drive", line_pull_low, 0);
    chk("R1 flags", {parity_err, noise_err, frame_err}, 0);
    chk("R1 data", rx_data, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 5; i++) tick(1'b1);

    // R5 R6 plain frame
    send_frame(8'hA5, 0, -1, 0, 0, 4);
    check_frame(8'hA5, 0, 0, 0);

    // R8 character mode: nack regardless of nack_en
    block_mode = 0; nack_en = 0;
    send_frame(8'h3C, 1, -1, 0, 0, 4);
    check_frame(8'h3C, 1, 0, 0);

    // R9 block mode with NACK disabled: no drive
    block_mode = 1; nack_en = 0;
    send_frame(8'h81, 1, -1, 0, 0, 4);
    check_frame(8'h81, 1, 0, 0);

    // R9 block mode with NACK enabled
    block_mode = 1; nack_en = 1;
    send_frame(8'h7E, 1, -1, 0, 0, 4);
    check_frame(8'h7E, 1, 0, 0);

    // R4 start glitch rejected
    got = 0;
    for (int i = 0; i < 3; i++) tick(1'b0);
    for (int i = 0; i < 30; i++) tick(1'b1);
    chk("R4 glitch ignored", got, 0);
    chk("R4 no drive", line_pull_low, 0);
    send_frame(8'h12, 0, -1, 0, 0, 4);
    check_frame(8'h12, 0, 0, 0);

    // R2 R3 noise in start bit at tick 9
    send_frame(8'h00, 0, 0, 9, 0, 4);
    check_frame(8'h00, 0, 1, 0);

    // R7 stop period held low
    block_mode = 0; nack_en = 0;
    send_frame(8'hFF, 0, -1, 0, 1, 4);
    check_frame(8'hFF, 0, 0, 1);

    // R10 back-to-back: next start on first tick after stop
    send_frame(8'h5A, 1, -1, 0, 0, 0);
    check_frame(8'h5A, 1, 0, 0);
    send_frame(8'hC3, 0, -1, 0, 0, 4);
    check_frame(8'hC3, 0, 0, 0);

    // random mix
    for (int i = 0; i < 40; i++) begin
      logic [7:0] d;
      bit flip, noisy;
      int nbit, ntick;
      d = 8'($urandom);
      flip = 1'($urandom);
      block_mode = 1'($urandom);
      nack_en = 1'($urandom);
      noisy = 1'($urandom);
      nbit = noisy ? int'($urandom_range(0, 10)) : -1;
      ntick = int'($urandom_range(8, 10));
      send_frame(d, flip, nbit, ntick, 0, int'($urandom_range(0, 6)));
      check_frame(d, flip, noisy, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule